// File: doc/BRIEF.md
# Six-Channel Output Compare Unit with Force Strobes

The unit watches a shared free-running counter and drives six output pins, numbered as channels 2 to 7. Each channel holds a compare value and a two-bit pin action. When the counter equals a selected channel's compare value, the channel applies its action to its pin and raises its event flag. Software can also fire any channel's action at once by writing a strobe register. A forced action never raises a flag.

Channel 7 is a master channel. On a compare or a force of channel 7, every channel picked by a mask register copies its pin level from a master data register. This override beats anything channels 2 to 6 do in the same cycle.

All configuration uses a small synchronous register port with address, write data, write strobe and combinational read data. The counter arrives as an input. The pin levels, pin output-enables and event flags are outputs.

Top module: `occmp_unit`

## Requirements
- R1: While `rst` is high, every register clears at the clock edge. After reset, `pin_out`, `pin_oe` and `cmp_flag` are all zero.
- R2: A channel x whose select bit (address 0x0, bit x) is set has a compare event in every cycle where `count` equals its compare register. The compare register sits at address 0x8+x, so channel 2 is at 0xA and channel 7 is at 0xF. After the next clock edge, the pin has taken its action and flag bit x is 1.
- R3: The action field of channel x is bits [2(x-2)+1 : 2(x-2)] of address 0x4. The codes are: 00 leaves the pin unchanged, 01 toggles it, 10 drives it low and 11 drives it high.
- R4: Writing address 0x1 with bit x set applies channel x's action at the next edge, whatever the state of its select bit. It leaves flag x unchanged. Address 0x1 always reads zero.
- R5: If a force on channel x and a compare event on channel x fall in the same cycle, the action is applied once and flag x stays clear.
- R6: On a channel 7 compare event or force, each channel x from 2 to 6 with mask bit x set (address 0x2) takes bit x of the master data register (address 0x3). This overrides that channel's own action in the same cycle.
- R7: On a channel 7 event, pin 7 takes bit 7 of the master data register when mask bit 7 is set. Otherwise it takes channel 7's own action.
- R8: `pin_oe[x]` is 1 exactly when select bit x is set and either the channel's action code is non-zero or its mask bit is set.
- R9: Writing address 0x5 clears each flag whose data bit is 1. A compare event in the same cycle keeps that flag set.
- R10: Addresses 0x0, 0x2, 0x3, 0x4 and 0x8+x read back what was written, in the bit positions given above. All other bits read zero.
- R11: A channel whose select bit is clear has no compare events. Its pin and flag do not change when `count` equals its compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| count | input | CNT_W | Shared free-running counter value |
| pin_out | output | 6 | Pin levels, bit x is channel x (bits 7:2) |
| pin_oe | output | 6 | Pin output-enables, bits 7:2 |
| cmp_flag | output | 6 | Compare event flags, bits 7:2 |

## Verification
The bench builds the unit with the default 16-bit counter and register width. It holds the counter at a value that matches no channel and presents chosen values for single cycles. This lets every compare event be placed in an exact cycle. With that control, a force, a clear and a master override can be lined up in the same cycle as a compare. That setup reaches the precedence rules between the master override, forced actions and flag clears.

// File: rtl/occmp_unit.sv
module occmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0] count,
  output logic [7:2]       pin_out,
  output logic [7:2]       pin_oe,
  output logic [7:2]       cmp_flag
);

  localparam logic [3:0] A_SEL = 4'h0, A_FORCE = 4'h1, A_MASK = 4'h2,
                         A_DATA7 = 4'h3, A_ACT = 4'h4, A_FLAG = 4'h5;

  logic [7:2]       sel_q, mask_q, data7_q, pin_q, flag_q;
  logic [11:0]      act_q;
  logic [CNT_W-1:0] cmp_q [2:7];
  logic [7:2]       match, force_v, clr_v, pin_nx, flag_nx;
  logic             ev7;

  function automatic logic apply_act(input logic cur, input logic [1:0] a);
    case (a)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  assign force_v = (reg_wr && reg_addr == A_FORCE) ? reg_wdata[7:2] : '0;
  assign clr_v   = (reg_wr && reg_addr == A_FLAG)  ? reg_wdata[7:2] : '0;
  assign ev7     = match[7] | force_v[7];

  for (genvar x = 2; x <= 7; x++) begin : g_ch
    logic [1:0] act;
    assign act        = act_q[2*(x-2) +: 2];
    assign match[x]   = sel_q[x] && (count == cmp_q[x]);
    assign flag_nx[x] = (match[x] && !force_v[x]) || (flag_q[x] && !clr_v[x]);
    assign pin_oe[x]  = sel_q[x] && ((act != 2'b00) || mask_q[x]);
    if (x == 7) begin : g_master
      assign pin_nx[x] = !ev7 ? pin_q[x] :
                         mask_q[x] ? data7_q[x] : apply_act(pin_q[x], act);
    end else begin : g_slave
      assign pin_nx[x] = (ev7 && mask_q[x]) ? data7_q[x] :
                         (force_v[x] || match[x]) ? apply_act(pin_q[x], act) : pin_q[x];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      mask_q  <= '0;
      data7_q <= '0;
      act_q   <= '0;
      pin_q   <= '0;
      flag_q  <= '0;
      for (int i = 2; i <= 7; i++) cmp_q[i] <= '0;
    end else begin
      pin_q  <= pin_nx;
      flag_q <= flag_nx;
      if (reg_wr) begin
        case (reg_addr)
          A_SEL:   sel_q   <= reg_wdata[7:2];
          A_MASK:  mask_q  <= reg_wdata[7:2];
          A_DATA7: data7_q <= reg_wdata[7:2];
          A_ACT:   act_q   <= reg_wdata[11:0];
          default: ;
        endcase
        for (int i = 2; i <= 7; i++)
          if (reg_addr == 4'(8 + i)) cmp_q[i] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SEL:   reg_rdata[7:2]  = sel_q;
      A_MASK:  reg_rdata[7:2]  = mask_q;
      A_DATA7: reg_rdata[7:2]  = data7_q;
      A_ACT:   reg_rdata[11:0] = act_q;
      A_FLAG:  reg_rdata[7:2]  = flag_q;
      default: ;
    endcase
    for (int i = 2; i <= 7; i++)
      if (reg_addr == 4'(8 + i)) reg_rdata = cmp_q[i];
  end

  assign pin_out  = pin_q;
  assign cmp_flag = flag_q;

endmodule

module occmp_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       reg_addr,
  input logic             reg_wr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] reg_rdata,
  input logic [7:2]       match,
  input logic [7:2]       mask_q,
  input logic [7:2]       data7_q,
  input logic [7:2]       pin_out,
  input logic [7:2]       pin_oe,
  input logic [7:2]       cmp_flag
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && cmp_flag == '0));

  // R4
  force_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 4'h1) |-> (reg_rdata == '0));

  for (genvar x = 2; x <= 7; x++) begin : g_chk
    // R5
    force_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == 4'h1 && reg_wdata[x] && !cmp_flag[x]) |=> !cmp_flag[x]);
    // R2
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (match[x] && !(reg_wr && reg_addr == 4'h1 && reg_wdata[x])) |=> cmp_flag[x]);
    if (x < 7) begin : g_slave
      // R6
      master_override_chk: assert property (@(posedge clk) disable iff (rst)
        (match[7] && mask_q[x]) |=> (pin_out[x] == $past(data7_q[x])));
    end
  end

endmodule

bind occmp_unit occmp_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match(match),
  .mask_q(mask_q), .data7_q(data7_q), .pin_out(pin_out),
  .pin_oe(pin_oe), .cmp_flag(cmp_flag)
);

// File: tb/occmp_unit_test.sv
module occmp_unit_test;
  localparam int CNT_W = 16;
  localparam logic [15:0] IDLE = 16'h1234;

  logic             clk = 1'b0, rst = 1'b1, reg_wr = 1'b0;
  logic [3:0]       reg_addr = 4'h0;
  logic [CNT_W-1:0] reg_wdata = '0, count = IDLE;
  logic [CNT_W-1:0] reg_rdata;
  logic [7:2]       pin_out, pin_oe, cmp_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  occmp_unit #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count),
    .pin_out(pin_out), .pin_oe(pin_oe), .cmp_flag(cmp_flag));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pins();  return {8'h0, pin_out, 2'b00};  endfunction
  function automatic logic [15:0] oes();   return {8'h0, pin_oe, 2'b00};   endfunction
  function automatic logic [15:0] flags(); return {8'h0, cmp_flag, 2'b00}; endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk); count = v;
    @(negedge clk); count = IDLE;
  endtask

  task automatic wr_pulse(input logic [3:0] a, input logic [15:0] d, input logic [15:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d; count = v;
    @(negedge clk); reg_wr = 1'b0; count = IDLE;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 pins", pins(), 16'h0);
    chk("R1 oe", oes(), 16'h0);
    chk("R1 flags", flags(), 16'h0);
    rd(4'h4, d); chk("R1 act reg", d, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(4'hB, 16'hBEEF); rd(4'hB, d); chk("R10 cmp ch3", d, 16'hBEEF);
    wr(4'h4, 16'hFABC); rd(4'h4, d); chk("R10 act", d, 16'h0ABC);
    wr(4'h3, 16'hFFFF); rd(4'h3, d); chk("R10 data7", d, 16'h00FC);
    wr(4'h4, 16'h0); wr(4'h3, 16'h0);
  endtask

  task automatic t_actions();
    wr(4'h0, 16'h003C);
    wr(4'h4, 16'h0039);
    for (int x = 2; x <= 5; x++) wr(4'(8 + x), 16'h0100);
    chk("R8 oe", oes(), 16'h001C);
    pulse(16'h0100);
    chk("R2 R3 pins", pins(), 16'h0014);
    chk("R2 flags", flags(), 16'h003C);
    pulse(16'h0100);
    chk("R3 toggle back", pins(), 16'h0010);
  endtask

  task automatic t_clear();
    wr(4'h5, 16'h000C);
    chk("R9 partial clear", flags(), 16'h0030);
    wr_pulse(4'h5, 16'h0004, 16'h0100);
    chk("R9 set wins", flags(), 16'h003C);
    chk("R9 pins", pins(), 16'h0014);
    wr(4'h5, 16'h00FC);
    chk("R9 full clear", flags(), 16'h0000);
  endtask

  task automatic t_force();
    logic [15:0] d;
    wr(4'h1, 16'h0004);
    chk("R4 forced toggle", pins(), 16'h0010);
    chk("R4 no flag", flags(), 16'h0000);
    wr(4'h1, 16'h0020);
    chk("R3 hold on force", pins(), 16'h0010);
    rd(4'h1, d); chk("R4 reads zero", d, 16'h0);
    wr_pulse(4'h1, 16'h0004, 16'h0100);
    chk("R5 single toggle", pins(), 16'h0014);
    chk("R5 flag clear", flags(), 16'h0038);
    wr(4'h5, 16'h00FC);
  endtask

  task automatic t_nosel();
    wr(4'h0, 16'h0000);
    chk("R8 oe off", oes(), 16'h0000);
    pulse(16'h0100);
    chk("R11 pins", pins(), 16'h0014);
    chk("R11 flags", flags(), 16'h0000);
  endtask

  task automatic t_master();
    wr(4'h0, 16'h00FC);
    wr(4'h4, 16'h0139);
    wr(4'hE, 16'h0100);
    wr(4'hF, 16'h0200);
    wr(4'h2, 16'h0098);
    wr(4'h3, 16'h0088);
    chk("R8 oe mask", oes(), 16'h00DC);
    pulse(16'h0200);
    chk("R6 R7 masked copy", pins(), 16'h008C);
    chk("R2 ch7 flag", flags(), 16'h0080);
    wr(4'hF, 16'h0100);
    wr(4'h3, 16'h0000);
    pulse(16'h0100);
    chk("R6 override", pins(), 16'h0040);
    chk("R6 flags", flags(), 16'h00FC);
    wr(4'h3, 16'h0018);
    wr(4'h1, 16'h0080);
    chk("R6 forced master", pins(), 16'h0058);
    chk("R4 flags kept", flags(), 16'h00FC);
    wr(4'h2, 16'h0018);
    wr(4'h4, 16'h0D39);
    wr(4'h1, 16'h0080);
    chk("R7 own action", pins(), 16'h00D8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_actions();
    t_clear();
    t_force();
    t_nosel();
    t_master();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule